// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block carries out exactly one step of a non-restoring division each time it is commanded. It keeps three status bits between steps: a partial-quotient sign bit Q, the divisor sign bit M, and a carry-out bit T that also holds the quotient bit the step just produced. Each step shifts the supplied partial remainder left by one, moves the current T into the freed low bit, and then adds or subtracts the divisor. The choice between add and subtract depends on whether the stored Q matches M. After the step, Q is recomputed and T is set from the comparison of Q with M.

A controller outside the block issues a setup command first. The unsigned setup clears all three bits. The signed setup loads Q and M from the sign bits of dividend and divisor. The controller then issues one step per quotient bit and feeds each registered remainder back in. The quotient collects in the low end of the remainder through T. For a `WIDTH`-bit unit with a half-width dividend and the divisor placed in the upper half, `WIDTH/2` steps followed by one final shift-in of T give the unsigned quotient. The full-division sequencing, sign correction and register-file connection stay with the controller.

Top module: `divstep_unit`

## Requirements
- R1: After reset, `rem_o`, `q_o`, `t_o` and `done_o` are all 0, and the stored divisor-sign bit is 0.
- R2: An unsigned setup (`init_u_i`=1, `init_s_i`=0) clears Q, M and T at the next clock edge. It leaves `rem_o` unchanged and does not raise `done_o`.
- R3: A signed setup (`init_s_i`=1) loads Q from bit `WIDTH-1` of `rem_i` and M from bit `WIDTH-1` of `divisor_i`, and sets T to Q xor M. It leaves `rem_o` unchanged and does not raise `done_o`.
- R4: Commands are ranked signed setup, then unsigned setup, then step. A step strobe in the same cycle as either setup is ignored: `rem_o` holds and `done_o` stays 0.
- R5: In a cycle with no command, `rem_o`, `q_o` and `t_o` hold their values and `done_o` is 0 in the next cycle.
- R6: A step forms S = {`rem_i`[`WIDTH-2`:0], T}. It computes S − `divisor_i` when the stored Q equals M, and S + `divisor_i` otherwise, modulo 2^`WIDTH`, and registers that result on `rem_o`.
- R7: A step sets the new Q to `rem_i`[`WIDTH-1`] xor F xor M. F is the borrow of the subtraction (the result is greater than S) or the carry of the addition (the result is less than S).
- R8: After a step, T is 1 exactly when the new Q equals M.
- R9: `done_o` is 1 for exactly the one cycle after each accepted step. In that same cycle the registered results of the step are visible.
- R10: After an unsigned setup, load the divisor D in the upper half and a half-width dividend N in the lower half. Run `WIDTH/2` steps, feeding `rem_o` back each time. The low `WIDTH/2` bits of {`rem_o`[`WIDTH-2`:0], `t_o`} then equal N / D, for D ≠ 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Perform one division step this cycle |
| init_u_i | input | 1 | Unsigned setup: clear Q, M, T |
| init_s_i | input | 1 | Signed setup: load Q, M from the operand signs |
| divisor_i | input | WIDTH | Divisor operand |
| rem_i | input | WIDTH | Partial remainder (or dividend, for signed setup) |
| rem_o | output | WIDTH | Registered partial remainder after the last step |
| q_o | output | 1 | Current Q bit |
| t_o | output | 1 | Current T bit (latest quotient bit) |
| done_o | output | 1 | One-cycle pulse following an accepted step |

## Verification
The assertions assume the command inputs are stable, known levels at each rising edge. They also assume the operands supplied with a step or a setup are valid in that same cycle. They place no limit on how commands overlap, since the ranking in R4 defines every combination. The bench drives all inputs on the falling edge and holds each command for exactly one cycle. It also deliberately raises a step together with a setup, so that the ranked cases are exercised as well as the single-command ones.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_STEP   = 2'd1,
    CMD_INIT_U = 2'd2,
    CMD_INIT_S = 2'd3
  } divstep_cmd_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } divstep_flags_t;

endpackage

// File: rtl/divstep_cmd_dec.sv
module divstep_cmd_dec
  import divstep_pkg::*;
(
  input  logic         step_i,
  input  logic         init_u_i,
  input  logic         init_s_i,
  output divstep_cmd_e cmd_o
);

  always_comb begin
    if (init_s_i) begin
      cmd_o = CMD_INIT_S;
    end else if (init_u_i) begin
      cmd_o = CMD_INIT_U;
    end else if (step_i) begin
      cmd_o = CMD_STEP;
    end else begin
      cmd_o = CMD_IDLE;
    end
  end

endmodule

// File: rtl/divstep_shift.sv
module divstep_shift #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic             t_i,
  output logic [WIDTH-1:0] shifted_o,
  output logic             msb_o
);

  always_comb begin
    msb_o     = rem_i[WIDTH-1];
    shifted_o = {rem_i[WIDTH-2:0], t_i};
  end

endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
  parameter int WIDTH      = 32,
  parameter bit WIDE_ADDER = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             flag_o
);

  localparam int EXT_W = WIDTH + 1;

  generate
    if (WIDE_ADDER) begin : g_wide
      logic [EXT_W-1:0] ext_sum;
      always_comb begin
        if (sub_i) begin
          ext_sum = {1'b0, a_i} - {1'b0, b_i};
        end else begin
          ext_sum = {1'b0, a_i} + {1'b0, b_i};
        end
        sum_o  = ext_sum[WIDTH-1:0];
        flag_o = ext_sum[WIDTH];
      end
    end else begin : g_cmp
      always_comb begin
        if (sub_i) begin
          sum_o  = a_i - b_i;
          flag_o = (sum_o > a_i);
        end else begin
          sum_o  = a_i + b_i;
          flag_o = (sum_o < a_i);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/divstep_qt.sv
module divstep_qt (
  input  logic msb_i,
  input  logic flag_i,
  input  logic m_i,
  output logic q_o,
  output logic t_o
);

  always_comb begin
    q_o = msb_i ^ flag_i ^ m_i;
    t_o = (q_o == m_i);
  end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit WIDE_ADDER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             init_u_i,
  input  logic             init_s_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic [WIDTH-1:0] rem_i,
  output logic [WIDTH-1:0] rem_o,
  output logic             q_o,
  output logic             t_o,
  output logic             done_o
);

  localparam int MSB = WIDTH - 1;

  divstep_cmd_e   cmd;
  divstep_flags_t flags_q;
  divstep_flags_t flags_d;
  logic [MSB:0]   rem_q;
  logic [MSB:0]   rem_d;
  logic           done_q;
  logic           done_d;
  logic           rem_en;
  logic           flags_en;

  logic [MSB:0]   shifted;
  logic           msb;
  logic           use_sub;
  logic [MSB:0]   op_result;
  logic           op_flag;
  logic           step_q;
  logic           step_t;

  divstep_cmd_dec u_cmd (
    .step_i   (step_i),
    .init_u_i (init_u_i),
    .init_s_i (init_s_i),
    .cmd_o    (cmd)
  );

  divstep_shift #(.WIDTH(WIDTH)) u_shift (
    .rem_i     (rem_i),
    .t_i       (flags_q.t),
    .shifted_o (shifted),
    .msb_o     (msb)
  );

  assign use_sub = (flags_q.q == flags_q.m);

  divstep_addsub #(.WIDTH(WIDTH), .WIDE_ADDER(WIDE_ADDER)) u_addsub (
    .a_i    (shifted),
    .b_i    (divisor_i),
    .sub_i  (use_sub),
    .sum_o  (op_result),
    .flag_o (op_flag)
  );

  divstep_qt u_qt (
    .msb_i  (msb),
    .flag_i (op_flag),
    .m_i    (flags_q.m),
    .q_o    (step_q),
    .t_o    (step_t)
  );

  // next-state selection
  always_comb begin
    flags_d  = flags_q;
    rem_d    = rem_q;
    done_d   = 1'b0;
    rem_en   = 1'b0;
    flags_en = 1'b0;
    unique case (cmd)
      CMD_INIT_S: begin
        flags_en  = 1'b1;
        flags_d.q = rem_i[MSB];
        flags_d.m = divisor_i[MSB];
        flags_d.t = rem_i[MSB] ^ divisor_i[MSB];
      end
      CMD_INIT_U: begin
        flags_en = 1'b1;
        flags_d  = '0;
      end
      CMD_STEP: begin
        flags_en  = 1'b1;
        rem_en    = 1'b1;
        done_d    = 1'b1;
        rem_d     = op_result;
        flags_d.q = step_q;
        flags_d.m = flags_q.m;
        flags_d.t = step_t;
      end
      default: begin
        flags_en = 1'b0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign rem_o  = rem_q;
  assign q_o    = flags_q.q;
  assign t_o    = flags_q.t;
  assign done_o = done_q;

endmodule

// File: rtl/divstep_chk.sv
module divstep_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_i,
  input logic             init_u_i,
  input logic             init_s_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic [WIDTH-1:0] rem_i,
  input logic [WIDTH-1:0] rem_o,
  input logic             q_o,
  input logic             t_o,
  input logic             done_o,
  input logic             m_state
);

  logic any_init;
  logic plain_step;
  assign any_init   = init_u_i | init_s_i;
  assign plain_step = step_i & ~any_init;

  // R1: reset leaves every output low
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (rem_o == '0 && !q_o && !t_o && !done_o && !m_state);
    end
  end

  // R2
  a_r2_unsigned_init: assert property (@(posedge clk) disable iff (!rst_n)
    (init_u_i && !init_s_i) |=> (!q_o && !t_o && !m_state && !done_o && $stable(rem_o)));

  // R3
  a_r3_signed_init: assert property (@(posedge clk) disable iff (!rst_n)
    init_s_i |=> (q_o == $past(rem_i[WIDTH-1]) && m_state == $past(divisor_i[WIDTH-1])
                  && t_o == ($past(rem_i[WIDTH-1]) ^ $past(divisor_i[WIDTH-1]))));

  // R4
  a_r4_init_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && any_init) |=> (!done_o && $stable(rem_o)));

  // R5
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !any_init) |=> ($stable(rem_o) && $stable(q_o) && $stable(t_o) && !done_o));

  // R6: low bit of the result is the old T combined with the divisor low bit
  a_r6_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    plain_step |=> (rem_o[0] == ($past(t_o) ^ $past(divisor_i[0]))));

  // R6: M is never changed by a step
  a_r6_m_kept: assert property (@(posedge clk) disable iff (!rst_n)
    plain_step |=> $stable(m_state));

  // R8
  a_r8_t_from_qm: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (t_o == (q_o == m_state)));

  // R9
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    plain_step |=> done_o);

endmodule

bind divstep_unit divstep_chk #(.WIDTH(WIDTH)) u_divstep_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_i    (step_i),
  .init_u_i  (init_u_i),
  .init_s_i  (init_s_i),
  .divisor_i (divisor_i),
  .rem_i     (rem_i),
  .rem_o     (rem_o),
  .q_o       (q_o),
  .t_o       (t_o),
  .done_o    (done_o),
  .m_state   (flags_q.m)
);

// File: tb/tb_divstep_unit.sv
`timescale 1ns/1ps
module tb_divstep_unit;

  localparam int W    = 64;
  localparam int HALF = W / 2;

  logic         clk;
  logic         rst_n;
  logic         step_i;
  logic         init_u_i;
  logic         init_s_i;
  logic [W-1:0] divisor_i;
  logic [W-1:0] rem_i;
  logic [W-1:0] rem_o;
  logic         q_o;
  logic         t_o;
  logic         done_o;

  int checks;
  int fails;
  bit finished;

  divstep_unit #(.WIDTH(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_i),
    .init_u_i  (init_u_i),
    .init_s_i  (init_s_i),
    .divisor_i (divisor_i),
    .rem_i     (rem_i),
    .rem_o     (rem_o),
    .q_o       (q_o),
    .t_o       (t_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one command cycle, sampled at the following falling edge
  task automatic issue(input logic st, input logic iu, input logic is,
                       input logic [W-1:0] dv, input logic [W-1:0] rm);
    @(negedge clk);
    step_i = st; init_u_i = iu; init_s_i = is; divisor_i = dv; rem_i = rm;
    @(negedge clk);
    step_i = 1'b0; init_u_i = 1'b0; init_s_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rem", rem_o, '0);
    check("R1 q", {63'b0, q_o}, '0);
    check("R1 t", {63'b0, t_o}, '0);
    check("R1 done", {63'b0, done_o}, '0);
  endtask

  // hand-computed single steps, unsigned and signed setups
  task automatic t_steps();
    issue(0, 1, 0, '0, '0);
    check("R2 q", {63'b0, q_o}, '0);
    check("R2 t", {63'b0, t_o}, '0);
    // Q=M=T=0: subtract, 0xA-3=7, no borrow -> Q=0, T=1
    issue(1, 0, 0, 64'd3, 64'd5);
    check("R6 sub rem", rem_o, 64'd7);
    check("R7 q", {63'b0, q_o}, 64'd0);
    check("R8 t", {63'b0, t_o}, 64'd1);
    check("R9 done", {63'b0, done_o}, 64'd1);
    // S=3, 3-5 borrows -> Q=1, T=0
    issue(1, 0, 0, 64'd5, 64'd1);
    check("R6 sub wrap", rem_o, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R7 borrow q", {63'b0, q_o}, 64'd1);
    check("R8 t", {63'b0, t_o}, 64'd0);
    // Q=1,M=0: add, S=8, 8+2=10, msb 1, no carry -> Q=1
    issue(1, 0, 0, 64'd2, 64'h8000_0000_0000_0004);
    check("R6 add rem", rem_o, 64'd10);
    check("R7 add q", {63'b0, q_o}, 64'd1);
    // R5: idle cycle holds and done falls
    issue(0, 0, 0, 64'd9, 64'd9);
    check("R5 rem hold", rem_o, 64'd10);
    check("R5 q hold", {63'b0, q_o}, 64'd1);
    check("R9 done single", {63'b0, done_o}, 64'd0);
    // R3: negative dividend, positive divisor -> Q=1, T=1
    issue(0, 0, 1, 64'd1, 64'h8000_0000_0000_0000);
    check("R3 q", {63'b0, q_o}, 64'd1);
    check("R3 t", {63'b0, t_o}, 64'd1);
    check("R3 rem kept", rem_o, 64'd10);
    // Q=1,M=0,T=1: add, S=1, 1+1=2, Q=1, T=0
    issue(1, 0, 0, 64'd1, 64'h8000_0000_0000_0000);
    check("R6 signed add", rem_o, 64'd2);
    check("R8 t", {63'b0, t_o}, 64'd0);
    // positive dividend, negative divisor -> Q=0,M=1,T=1
    issue(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3);
    check("R3 t", {63'b0, t_o}, 64'd1);
    // add: S=7, 7+(-2)=5 with carry -> Q=0^1^1=0, T=0
    issue(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3);
    check("R6 add neg", rem_o, 64'd5);
    check("R7 carry m1", {63'b0, q_o}, 64'd0);
    check("R8 t", {63'b0, t_o}, 64'd0);
    // both negative -> Q=1,M=1,T=0
    issue(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 q", {63'b0, q_o}, 64'd1);
    check("R3 t", {63'b0, t_o}, 64'd0);
    // Q==M: subtract, S=4, 4-(-1)=5 borrow -> Q=0, T=0
    issue(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    check("R6 sub m1", rem_o, 64'd5);
    check("R7 borrow m1", {63'b0, q_o}, 64'd0);
  endtask

  // R4: a step together with a setup is dropped
  task automatic t_priority();
    issue(1, 1, 0, 64'd1, 64'd100);
    check("R4 rem held", rem_o, 64'd5);
    check("R4 no done", {63'b0, done_o}, 64'd0);
    check("R2 q cleared", {63'b0, q_o}, 64'd0);
    // both setups plus step: signed setup wins
    issue(1, 1, 1, 64'd1, 64'h8000_0000_0000_0000);
    check("R4 signed wins q", {63'b0, q_o}, 64'd1);
    check("R4 signed wins t", {63'b0, t_o}, 64'd1);
    check("R4 rem held", rem_o, 64'd5);
  endtask

  task automatic divide(input logic [HALF-1:0] n, input logic [HALF-1:0] d);
    logic [HALF-1:0] quo;
    issue(0, 1, 0, '0, '0);
    @(negedge clk);
    rem_i = {{HALF{1'b0}}, n};
    divisor_i = {d, {HALF{1'b0}}};
    for (int i = 0; i < HALF; i++) begin
      step_i = 1'b1;
      @(negedge clk);
      rem_i = rem_o;
    end
    step_i = 1'b0;
    quo = {rem_o[HALF-2:0], t_o};
    check("R10 quotient", {{HALF{1'b0}}, quo}, {{HALF{1'b0}}, n / d});
  endtask

  task automatic t_divide();
    divide(32'd100, 32'd7);
    divide(32'd0, 32'd5);
    divide(32'hFFFF_FFFF, 32'd1);
    divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    divide(32'd6, 32'd9);
    for (int k = 0; k < 20; k++) begin
      logic [HALF-1:0] rn;
      logic [HALF-1:0] rd;
      rn = $urandom;
      rd = $urandom;
      if (rd == '0) rd = 32'd3;
      if (k[0]) rd = rd >> (k % 31);
      if (rd == '0) rd = 32'd1;
      divide(rn, rd);
    end
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    rst_n = 1'b0; step_i = 1'b0; init_u_i = 1'b0; init_s_i = 1'b0;
    divisor_i = '0; rem_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_steps();
    t_priority();
    t_divide();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule